// File: doc/BRIEF.md
# Multiphase Control Point Decoder

This block drives the control points of a logic built-in self-test run from a phase decoder rather than from the pattern generator. It watches the BIST pattern counter and splits the run into five equal phases, each `PHASE_LEN` patterns long. It turns the current phase into four registered control-point enables, C1 to C4. Within a phase the enables stay fixed. When the counter crosses into the next phase, they all change together on the same clock edge.

Each enable gates an AND-type control point. The block contains a small model of those four gated nets so that the effect of the enables can be seen at the ports. A one-hot target output names the logic region that the current phase aims at: A, B, C or D, or none in phase 0. The phase register starts at phase 0 on BIST reset. It moves forward only, and it stays at the last phase until the next reset.

Top module: `mtp_phase_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `phase_o` is 0, `cp_en` is 4'b0000 and `tgt_sel` is 4'b0000.
- R2: When `pat_cnt` is sampled on a rising clock edge, `phase_o` after that edge is the larger of its old value and min(`pat_cnt` / `PHASE_LEN`, 4), using integer division. `cp_en` and `tgt_sel` update on that same edge.
- R3: In phase 0, `cp_en` is 4'b0000.
- R4: In phase k (1 to 4), exactly one enable is 0, and it is bit k-1. Bit 0 is C1. So phase 1 gives `cp_en` = 4'b1110, phase 2 gives 4'b1101, phase 3 gives 4'b1011 and phase 4 gives 4'b0111, written with bit 3 on the left.
- R5: `tgt_sel` is one-hot with bit k-1 set in phase k. Bit 0 is region A, bit 1 is B, bit 2 is C and bit 3 is D. In phase 0, `tgt_sel` is 4'b0000.
- R6: Once `phase_o` reaches 4, it stays at 4 until reset. This holds for counts above 4*`PHASE_LEN` and when the counter wraps to 0.
- R7: The phase never moves backward. A count that falls inside an earlier phase leaves `phase_o`, `cp_en` and `tgt_sel` unchanged.
- R8: `cp_out[i]` is 0 when `cp_en[i]` is 0 and equals `cp_in[i]` when `cp_en[i]` is 1. The path is combinational, with no clock delay.
- R9: `cp_en` changes only on an edge where `phase_o` changes. Count changes that stay inside one phase leave it constant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | BIST clock |
| rst_n | input | 1 | Active-low BIST reset, asynchronous assert |
| pat_cnt | input | CNT_W | BIST pattern counter value |
| cp_in | input | 4 | Nets entering the four AND control points |
| phase_o | output | 3 | Current phase, 0 to 4 |
| cp_en | output | 4 | Registered control-point enables; bit 0 is C1 |
| tgt_sel | output | 4 | One-hot target region; bit 0 is A |
| cp_out | output | 4 | Nets after the AND control points |

## Verification
On every cycle, the assertions check the shape of the decoder outputs:
- In phase 0, all enables are low.
- In phases 1 to 4, exactly one enable is low.
- The target output is one-hot or zero, in step with the phase.
- The phase never decreases, and it holds once it saturates.
- The enables change only together with the phase.
- A gated net is never high while its enable is low.

The assertions cannot tell whether the phase matches the counter value, or whether the cleared enable and the target bit fall on the right positions for each phase. The directed scenarios show these by sweeping the counter across every boundary. They also cover backward and wrapping counts, and they drive patterns through the gated nets.

// File: rtl/mtp_pkg.sv
package mtp_pkg;
    localparam int MTP_NUM_CP = 4;
    localparam int MTP_PH_W   = $clog2(MTP_NUM_CP + 1);

    typedef enum logic [MTP_PH_W-1:0] {
        PH_NONE = 3'd0,
        PH_A    = 3'd1,
        PH_B    = 3'd2,
        PH_C    = 3'd3,
        PH_D    = 3'd4
    } phase_e;

    typedef struct packed {
        logic [MTP_PH_W-1:0] phase;
    } track_st;

    typedef struct packed {
        logic [MTP_NUM_CP-1:0] en;
        logic [MTP_NUM_CP-1:0] tgt;
    } dec_st;
endpackage

// File: rtl/mtp_phase_track.sv
module mtp_phase_track
    import mtp_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int PHASE_LEN = 100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CNT_W-1:0]    pat_cnt,
    output logic [MTP_PH_W-1:0] phase_d_o,
    output logic [MTP_PH_W-1:0] phase_q_o
);
    track_st st_d, st_q;
    logic [MTP_PH_W-1:0] raw_ph;

    // Count boundaries crossed, saturating at the last phase.
    always_comb begin
        raw_ph = '0;
        for (int k = 1; k <= MTP_NUM_CP; k++) begin
            if (int'(pat_cnt) >= k * PHASE_LEN) begin
                raw_ph = raw_ph + 1'b1;
            end
        end
        st_d = st_q;
        if (raw_ph > st_q.phase) begin
            st_d.phase = raw_ph;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_d_o = st_d.phase;
    assign phase_q_o = st_q.phase;
endmodule

// File: rtl/mtp_en_decode.sv
module mtp_en_decode
    import mtp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [MTP_PH_W-1:0]   phase_d,
    output logic [MTP_NUM_CP-1:0] en_q_o,
    output logic [MTP_NUM_CP-1:0] tgt_q_o
);
    dec_st st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < MTP_NUM_CP; i++) begin
            st_d.en[i]  = (phase_d != PH_NONE) && (phase_d != MTP_PH_W'(i + 1));
            st_d.tgt[i] = (phase_d == MTP_PH_W'(i + 1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_q_o  = st_q.en;
    assign tgt_q_o = st_q.tgt;
endmodule

// File: rtl/mtp_and_cp.sv
module mtp_and_cp
    import mtp_pkg::*;
(
    input  logic [MTP_NUM_CP-1:0] net_in,
    input  logic [MTP_NUM_CP-1:0] en,
    output logic [MTP_NUM_CP-1:0] net_out
);
    for (genvar i = 0; i < MTP_NUM_CP; i++) begin : g_cp
        assign net_out[i] = net_in[i] & en[i];
    end
endmodule

// File: rtl/mtp_phase_ctrl.sv
module mtp_phase_ctrl
    import mtp_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int PHASE_LEN = 100
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CNT_W-1:0]      pat_cnt,
    input  logic [MTP_NUM_CP-1:0] cp_in,
    output logic [MTP_PH_W-1:0]   phase_o,
    output logic [MTP_NUM_CP-1:0] cp_en,
    output logic [MTP_NUM_CP-1:0] tgt_sel,
    output logic [MTP_NUM_CP-1:0] cp_out
);
    logic [MTP_PH_W-1:0] phase_d;

    mtp_phase_track #(.CNT_W(CNT_W), .PHASE_LEN(PHASE_LEN)) track_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pat_cnt   (pat_cnt),
        .phase_d_o (phase_d),
        .phase_q_o (phase_o)
    );

    mtp_en_decode dec_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_d (phase_d),
        .en_q_o  (cp_en),
        .tgt_q_o (tgt_sel)
    );

    mtp_and_cp gate_i (
        .net_in  (cp_in),
        .en      (cp_en),
        .net_out (cp_out)
    );
endmodule

// File: rtl/mtp_phase_ctrl_chk.sv
module mtp_phase_ctrl_chk
    import mtp_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic [MTP_PH_W-1:0]   phase_o,
    input logic [MTP_NUM_CP-1:0] cp_en,
    input logic [MTP_NUM_CP-1:0] tgt_sel,
    input logic [MTP_NUM_CP-1:0] cp_out
);
    p_idle_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_NONE) |-> (cp_en == '0));

    p_one_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != PH_NONE) |-> ($countones(~cp_en) == 1));

    p_tgt_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_sel) && ((phase_o == PH_NONE) == (tgt_sel == '0)));

    p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_D) |=> (phase_o == PH_D));

    p_no_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (phase_o >= $past(phase_o)));

    p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_out & ~cp_en) == '0);

    p_en_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(phase_o) |-> $stable(cp_en));
endmodule

bind mtp_phase_ctrl mtp_phase_ctrl_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_o (phase_o),
    .cp_en   (cp_en),
    .tgt_sel (tgt_sel),
    .cp_out  (cp_out)
);

// File: tb/mtp_phase_ctrl_tb_top.sv
`timescale 1ns/1ps
module mtp_phase_ctrl_tb_top;
    localparam int CW = 8;
    localparam int PL = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] pat_cnt = '0;
    logic [3:0]    cp_in = '0;
    logic [2:0]    phase_o;
    logic [3:0]    cp_en, tgt_sel, cp_out;

    int n_chk = 0;
    int n_bad = 0;
    int exp_ph = 0;

    always #2 clk = ~clk;

    mtp_phase_ctrl #(.CNT_W(CW), .PHASE_LEN(PL)) dut_i (
        .clk(clk), .rst_n(rst_n), .pat_cnt(pat_cnt), .cp_in(cp_in),
        .phase_o(phase_o), .cp_en(cp_en), .tgt_sel(tgt_sel), .cp_out(cp_out)
    );

    function automatic logic [3:0] en_of(int ph);
        return (ph == 0) ? 4'b0000 : (~(4'b0001 << (ph - 1)) & 4'hF);
    endfunction

    function automatic logic [3:0] tgt_of(int ph);
        return (ph == 0) ? 4'b0000 : (4'b0001 << (ph - 1));
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_outs(string req);
        chk({req, " phase"}, phase_o, exp_ph);
        chk({req, " en"}, cp_en, en_of(exp_ph));
        chk({req, " tgt"}, tgt_sel, tgt_of(exp_ph));
    endtask

    task automatic step(int cnt);
        int raw;
        @(negedge clk);
        pat_cnt = CW'(cnt);
        @(posedge clk);
        #1;
        raw = cnt / PL;
        if (raw > 4) raw = 4;
        if (raw > exp_ph) exp_ph = raw;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        pat_cnt = '0;
        exp_ph = 0;
        #1;
        chk_outs("R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk_outs("R1 after reset");
    endtask

    // R2 R3 R4 R5: sweep every count through all phases.
    task automatic t_sweep();
        do_reset();
        for (int c = 0; c < 5 * PL + 3; c++) begin
            step(c);
            chk_outs("R2 R3 R4 R5 sweep");
        end
    endtask

    // R9: counts inside one phase keep the enables steady.
    task automatic t_hold();
        logic [3:0] held;
        do_reset();
        step(2 * PL);
        held = cp_en;
        step(2 * PL + 5);
        chk("R9 hold", cp_en, held);
        step(2 * PL + 1);
        chk("R9 hold", cp_en, held);
        step(3 * PL - 1);
        chk("R9 hold", cp_en, held);
        step(3 * PL);
        chk_outs("R9 boundary");
    endtask

    // R7: a lower count leaves the phase and outputs unchanged.
    task automatic t_backward();
        do_reset();
        step(2 * PL + 4);
        step(3);
        chk_outs("R7 back");
        chk("R7 phase stays 2", phase_o, 2);
        step(PL + 1);
        chk("R7 phase stays 2", phase_o, 2);
        step(3 * PL);
        chk("R7 forward again", phase_o, 3);
    endtask

    // R6: saturate past the end and across wrap.
    task automatic t_saturate();
        do_reset();
        step(4 * PL);
        chk("R6 reach", phase_o, 4);
        step(255);
        chk("R6 above", phase_o, 4);
        step(0);
        chk("R6 wrap", phase_o, 4);
        chk("R6 wrap en", cp_en, 4'b0111);
        do_reset();
        chk("R6 cleared by reset", phase_o, 0);
    endtask

    // R8: combinational gating in every phase.
    task automatic t_gate();
        do_reset();
        for (int ph = 0; ph <= 4; ph++) begin
            step(ph * PL);
            for (int p = 0; p < 16; p++) begin
                cp_in = 4'(p);
                #0.2;
                chk("R8 gate", cp_out, 4'(p) & en_of(ph));
            end
        end
        cp_in = '0;
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL all requirements watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_sweep();
        t_hold();
        t_backward();
        t_saturate();
        t_gate();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule